// File: doc/BRIEF.md
# Flash Suspend/Resume Command Sequencer

This block runs the suspend and resume handshakes that a serial NOR flash needs when a long program or erase has to be paused for a read, or picked up again afterwards. Software starts an operation by pulsing a set strobe for the suspend or the resume pending bit. A hardware suspend request can do the same for suspend when automatic suspend is enabled. The sequencer then hands the matching opcode to an external SPI shifter through a valid/ready command port. It can pause for a programmable number of SPI clock cycles. After that it polls the flash status until the operation is confirmed, and clears the pending bit when it finishes.

Completion is judged on a status word of one or two bytes. The write-in-progress flag must be clear. In full-check mode, the bits selected by a 16-bit mask must also agree. For suspend, the status XORed with the mask must be zero at every mask position. For resume, the raw status must be zero at those positions. When the mask test keeps failing, a retry limit forces the check to pass. A chain option starts the resume on its own as soon as a suspend completes.

Opcodes: suspend 0x75, resume 0x7A, first status byte 0x05, second status byte 0x35. The package also provides the power-up settings an integrator should apply to the configuration inputs: mask 0x0080 and retry limit 4.

Top module: `fsr_seq`

## Requirements
- R1: Out of reset the block is idle: `busy`, `cmd_valid`, `done`, `sus_pend` and `res_pend` are 0. A `sus_set` pulse sets `sus_pend`, and the block issues opcode 0x75 and then at least one status read. On completion it pulses `done` for one cycle with `done_res`=0 and clears `sus_pend`.
- R2: A `res_set` pulse sets `res_pend` and runs the same flow with opcode 0x7A. It ends with `done` pulsed, `done_res`=1 and `res_pend` cleared.
- R3: If both strobes arrive in the same cycle, the suspend runs first and the resume runs after it. A strobe that arrives while the block is busy stays pending and is served once the block is idle again.
- R4: `auto_req` sets `sus_pend` only while `auto_en` is 1. With `auto_en`=0 it has no effect.
- R5: When the wait enable of the running operation is 1, the first status read is presented `hold_len`×4 cycles after the opcode is accepted, or `hold_len`×128 cycles when `hold_long`=1. The count is measured from the acceptance edge to the first cycle with `cmd_valid`, minus one. When the wait enable is 0, or `hold_len` is 0, that read follows in the next cycle.
- R6: Each poll sends 0x05 and takes one byte, which becomes status bits 7:0. When `two_byte`=1 it then sends 0x35 and takes a second byte, which becomes bits 15:8. Otherwise bits 15:8 are 0.
- R7: A poll whose status bit 0 (WIP) is 1 never completes the operation. It starts another poll and does not count toward the retry limit.
- R8: With `sus_full_chk`=1, a suspend completes when WIP is 0 and (status XOR `end_mask`) is zero at every bit set in `end_mask`. With `sus_full_chk`=0, WIP equal to 0 is enough.
- R9: With `res_full_chk`=1, a resume completes when WIP is 0 and the status is zero at every bit set in `end_mask`. With `res_full_chk`=0, WIP equal to 0 is enough.
- R10: The poll that brings the count of mask-test failures with WIP 0 up to `retry_lim` is treated as a pass. A limit of 0 or 1 passes on the first such failure.
- R11: With `chain_en`=1, a completed suspend is followed directly by a 0x7A opcode, without any `res_set`.
- R12: Once `cmd_valid` is raised, it stays high with a stable `cmd_op` until `cmd_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sus_set | input | 1 | Strobe that sets the suspend pending bit |
| res_set | input | 1 | Strobe that sets the resume pending bit |
| auto_en | input | 1 | Allows the hardware suspend request |
| auto_req | input | 1 | Hardware suspend request |
| chain_en | input | 1 | Start a resume right after a suspend completes |
| sus_wait_en | input | 1 | Pause after the suspend opcode |
| res_wait_en | input | 1 | Pause after the resume opcode |
| hold_len | input | HOLD_W | Pause length in units of 4 or 128 cycles |
| hold_long | input | 1 | 1: unit of 128 cycles, 0: unit of 4 cycles |
| two_byte | input | 1 | Read two status bytes per poll |
| sus_full_chk | input | 1 | Suspend end check includes the mask test |
| res_full_chk | input | 1 | Resume end check includes the mask test |
| end_mask | input | 16 | Status bits taking part in the mask test |
| retry_lim | input | RETRY_W | Mask-test failures that force a pass |
| cmd_valid | output | 1 | Command request to the shifter |
| cmd_ready | input | 1 | Shifter accepts the command |
| cmd_op | output | 8 | Opcode of the request |
| cmd_rd | output | 1 | Request expects one data byte back |
| rsp_valid | input | 1 | Returned status byte is valid |
| rsp_data | input | 8 | Returned status byte |
| sus_pend | output | 1 | Suspend pending bit |
| res_pend | output | 1 | Resume pending bit |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| done_res | output | 1 | Completed operation was a resume |

## Verification
Some rules are checked by assertions on every cycle. The command request is held with a stable opcode until it is accepted. The completion pulse lasts one cycle and clears the suspend pending bit. The hold timer counts down one step per cycle. A poll with WIP set always loops back. The failure count stays below the retry limit. A chained suspend completion shows the resume opcode in the same cycle. An auto request that is enabled sets the pending bit. Other behaviour only the bench scenarios can show, using a scripted flash. These are the exact opcode order for each combination of check mode, byte count, mask and retry limit, the measured pause lengths, the priority between simultaneous strobes, and the deferral of strobes that arrive while the block is busy.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int MASK_W = 16;

    localparam logic [7:0] OP_SUSPEND = 8'h75;
    localparam logic [7:0] OP_RESUME  = 8'h7A;
    localparam logic [7:0] OP_RDSR_LO = 8'h05;
    localparam logic [7:0] OP_RDSR_HI = 8'h35;

    // power-up settings an integrator applies to the configuration inputs
    localparam logic [MASK_W-1:0] DEF_END_MASK = 16'h0080;
    localparam int                DEF_RETRY    = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_HOLD, ST_POLL_LO,
        ST_WAIT_LO, ST_POLL_HI, ST_WAIT_HI, ST_JUDGE
    } seq_st_e;

    typedef enum logic {KIND_SUS = 1'b0, KIND_RES = 1'b1} op_kind_e;

    // mask test: suspend wants masked bits set, resume wants them clear
    function automatic logic mask_ok(op_kind_e kind,
                                     logic [MASK_W-1:0] raw,
                                     logic [MASK_W-1:0] mask);
        if (kind == KIND_SUS)
            return ((raw ^ mask) & mask) == '0;
        else
            return (raw & mask) == '0;
    endfunction

    function automatic logic [7:0] issue_op(op_kind_e kind);
        return (kind == KIND_RES) ? OP_RESUME : OP_SUSPEND;
    endfunction

endpackage

// File: rtl/fsr_trigger.sv
module fsr_trigger (
    input  logic clk,
    input  logic rst,
    input  logic sus_set,
    input  logic res_set,
    input  logic auto_en,
    input  logic auto_req,
    input  logic clr_sus,
    input  logic clr_res,
    output logic sus_pend,
    output logic res_pend
);
    logic sus_hit;
    assign sus_hit = sus_set | (auto_en & auto_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            sus_pend <= 1'b0;
            res_pend <= 1'b0;
        end else begin
            sus_pend <= sus_hit | (sus_pend & ~clr_sus);
            res_pend <= res_set | (res_pend & ~clr_res);
        end
    end

    // R4
    auto_sus_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && auto_req) |=> sus_pend);

endmodule

// File: rtl/fsr_hold_timer.sv
module fsr_hold_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt <= CNT_W'(1));

    // R5
    hold_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/fsr_judge.sv
module fsr_judge
    import fsr_pkg::*;
#(
    parameter int RETRY_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               eval,
    input  op_kind_e           kind,
    input  logic [MASK_W-1:0]  raw,
    input  logic [MASK_W-1:0]  mask,
    input  logic               full_chk,
    input  logic [RETRY_W-1:0] retry_lim,
    output logic               pass
);
    logic [RETRY_W-1:0] fail_cnt;
    logic               wip, bits_good, exhausted;

    always_comb begin
        wip       = raw[0];
        bits_good = mask_ok(kind, raw, mask);
        exhausted = ({1'b0, fail_cnt} + 1'b1) >= {1'b0, retry_lim};
        pass      = !wip && (!full_chk || bits_good || exhausted);
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            fail_cnt <= '0;
        else if (eval && !pass && !wip)
            fail_cnt <= fail_cnt + 1'b1;
    end

    // R10
    retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_cnt != '0) |-> (fail_cnt < retry_lim));

endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
    import fsr_pkg::*;
#(
    parameter int HOLD_W      = 10,
    parameter int RETRY_W     = 7,
    parameter int SHORT_SHIFT = 2,
    parameter int LONG_SHIFT  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sus_set,
    input  logic               res_set,
    input  logic               auto_en,
    input  logic               auto_req,
    input  logic               chain_en,
    input  logic               sus_wait_en,
    input  logic               res_wait_en,
    input  logic [HOLD_W-1:0]  hold_len,
    input  logic               hold_long,
    input  logic               two_byte,
    input  logic               sus_full_chk,
    input  logic               res_full_chk,
    input  logic [15:0]        end_mask,
    input  logic [RETRY_W-1:0] retry_lim,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [7:0]         cmd_op,
    output logic               cmd_rd,
    input  logic               rsp_valid,
    input  logic [7:0]         rsp_data,
    output logic               sus_pend,
    output logic               res_pend,
    output logic               busy,
    output logic               done,
    output logic               done_res
);
    localparam int TMR_W = HOLD_W + LONG_SHIFT;

    seq_st_e           st;
    op_kind_e          kind;
    logic [MASK_W-1:0] raw;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_load, tmr_last;
    logic              at_judge, judge_pass, finish, restart;
    logic              wait_sel, full_sel, clr_sus, clr_res;

    always_comb begin
        wait_sel = (kind == KIND_RES) ? res_wait_en : sus_wait_en;
        full_sel = (kind == KIND_RES) ? res_full_chk : sus_full_chk;
        tmr_val  = hold_long ? (TMR_W'(hold_len) << LONG_SHIFT)
                             : (TMR_W'(hold_len) << SHORT_SHIFT);
        tmr_load = (st == ST_ISSUE) && cmd_ready && wait_sel && (hold_len != '0);
        at_judge = (st == ST_JUDGE);
        finish   = at_judge && judge_pass;
        restart  = (st == ST_IDLE) || finish;
        clr_sus  = finish && (kind == KIND_SUS);
        clr_res  = finish && (kind == KIND_RES);
        busy     = (st != ST_IDLE);
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_RDSR_LO;
        cmd_rd    = 1'b1;
        unique case (st)
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_op    = issue_op(kind);
                cmd_rd    = 1'b0;
            end
            ST_POLL_LO: cmd_valid = 1'b1;
            ST_POLL_HI: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_RDSR_HI;
            end
            default: ;
        endcase
    end

    fsr_trigger u_trig (
        .clk(clk), .rst(rst), .sus_set(sus_set), .res_set(res_set),
        .auto_en(auto_en), .auto_req(auto_req),
        .clr_sus(clr_sus), .clr_res(clr_res),
        .sus_pend(sus_pend), .res_pend(res_pend)
    );

    fsr_hold_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
    );

    fsr_judge #(.RETRY_W(RETRY_W)) u_judge (
        .clk(clk), .rst(rst), .restart(restart), .eval(at_judge), .kind(kind),
        .raw(raw), .mask(end_mask), .full_chk(full_sel), .retry_lim(retry_lim),
        .pass(judge_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            kind     <= KIND_SUS;
            raw      <= '0;
            done     <= 1'b0;
            done_res <= 1'b0;
        end else begin
            done <= finish;
            if (finish) done_res <= (kind == KIND_RES);
            unique case (st)
                ST_IDLE: begin
                    if (sus_pend) begin
                        kind <= KIND_SUS;
                        st   <= ST_ISSUE;
                    end else if (res_pend) begin
                        kind <= KIND_RES;
                        st   <= ST_ISSUE;
                    end
                end
                ST_ISSUE:
                    if (cmd_ready) st <= tmr_load ? ST_HOLD : ST_POLL_LO;
                ST_HOLD:
                    if (tmr_last) st <= ST_POLL_LO;
                ST_POLL_LO:
                    if (cmd_ready) st <= ST_WAIT_LO;
                ST_WAIT_LO:
                    if (rsp_valid) begin
                        raw <= {8'h00, rsp_data};
                        st  <= two_byte ? ST_POLL_HI : ST_JUDGE;
                    end
                ST_POLL_HI:
                    if (cmd_ready) st <= ST_WAIT_HI;
                ST_WAIT_HI:
                    if (rsp_valid) begin
                        raw[15:8] <= rsp_data;
                        st        <= ST_JUDGE;
                    end
                ST_JUDGE: begin
                    if (!judge_pass)
                        st <= ST_POLL_LO;
                    else if (kind == KIND_SUS && chain_en) begin
                        kind <= KIND_RES;
                        st   <= ST_ISSUE;
                    end else
                        st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R12
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    sus_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !done_res && !$past(sus_set) && !$past(auto_en && auto_req))
        |-> !sus_pend);

    // R7
    wip_repoll_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_JUDGE && raw[0]) |=> (st == ST_POLL_LO));

    // R11
    chain_go_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !done_res && $past(chain_en)) |-> (cmd_valid && cmd_op == OP_RESUME));

endmodule

// File: tb/sim_fsr_seq.sv
`timescale 1ns/1ps
module sim_fsr_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic sus_set = 0, res_set = 0, auto_en = 0, auto_req = 0, chain_en = 0;
    logic sus_wait_en = 0, res_wait_en = 0, hold_long = 0, two_byte = 0;
    logic sus_full_chk = 0, res_full_chk = 0;
    logic [9:0]  hold_len = '0;
    logic [15:0] end_mask = 16'h0080;
    logic [6:0]  retry_lim = 7'd4;
    logic cmd_valid, cmd_ready = 1'b1, cmd_rd, rsp_valid = 1'b0;
    logic [7:0] cmd_op, rsp_data = '0;
    logic sus_pend, res_pend, busy, done, done_res;

    fsr_seq u0 (.*);

    int n_chk = 0, n_fail = 0, cyc = 0, last_gap = -1, op_hs_cyc = 0;
    bit gap_armed = 0, stall_en = 0, prev_stall = 0, pend_rsp = 0, summary_done = 0;
    logic [7:0] prev_op = '0;
    string cur_req = "R1";
    logic [7:0] exp_cmd[$];
    logic [7:0] script[$];
    bit exp_done[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            if (pend_rsp) begin
                rsp_valid = 1'b1;
                rsp_data  = (script.size() > 0) ? script.pop_front() : 8'h00;
                pend_rsp  = 0;
            end
            cmd_ready = !stall_en || (cyc % 3 == 2);
            if (prev_stall && cmd_valid)
                check(cmd_op == prev_op, "R12", cmd_op, prev_op);
            if (gap_armed && cmd_valid) begin
                last_gap  = cyc - op_hs_cyc;
                gap_armed = 0;
            end
            if (cmd_valid && cmd_ready) begin
                if (exp_cmd.size() == 0)
                    check(0, cur_req, cmd_op, 8'hff);
                else begin
                    logic [7:0] e;
                    e = exp_cmd.pop_front();
                    check(cmd_op == e, cur_req, cmd_op, e);
                end
                if (cmd_rd) pend_rsp = 1;
                if (!cmd_rd) begin
                    op_hs_cyc = cyc;
                    gap_armed = 1;
                end
            end
            prev_stall = cmd_valid && !cmd_ready;
            prev_op    = cmd_op;
            if (done) begin
                if (exp_done.size() == 0)
                    check(0, cur_req, done_res, 2);
                else begin
                    bit d;
                    d = exp_done.pop_front();
                    check(done_res == d, cur_req, done_res, d);
                end
            end
        end
    end

    task automatic ec(input logic [7:0] op); exp_cmd.push_back(op); endtask
    task automatic sb(input logic [7:0] b); script.push_back(b); endtask

    task automatic pulse(input bit s, input bit r);
        @(negedge clk);
        sus_set = s; res_set = r;
        @(negedge clk);
        sus_set = 0; res_set = 0;
    endtask

    task automatic wait_idle;
        int guard = 0;
        repeat (3) @(negedge clk);
        while ((busy || sus_pend || res_pend) && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 4000, cur_req, guard, 0);
        check(exp_cmd.size() == 0 && exp_done.size() == 0, cur_req,
              exp_cmd.size() + exp_done.size(), 0);
        script.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !cmd_valid && !done && !sus_pend && !res_pend, "R1",
              {busy, cmd_valid, done, sus_pend, res_pend}, 0);

        // R1 plain suspend, light check
        cur_req = "R1";
        ec(8'h75); ec(8'h05); exp_done.push_back(0); sb(8'h80);
        pulse(1, 0);
        wait_idle();
        check(!sus_pend, "R1", sus_pend, 0);

        // R2 plain resume; R9 light check ignores masked bit
        cur_req = "R2";
        ec(8'h7A); ec(8'h05); exp_done.push_back(1); sb(8'h80);
        pulse(0, 1);
        wait_idle();
        check(!res_pend, "R2", res_pend, 0);

        // R8 light suspend ignores masked bit
        cur_req = "R8";
        ec(8'h75); ec(8'h05); exp_done.push_back(0); sb(8'h00);
        pulse(1, 0);
        wait_idle();

        // R8 full suspend check: two failures then bits ok (limit 4)
        sus_full_chk = 1;
        ec(8'h75); ec(8'h05); ec(8'h05); ec(8'h05); exp_done.push_back(0);
        sb(8'h00); sb(8'h00); sb(8'h80);
        pulse(1, 0);
        wait_idle();

        // R7 WIP polls do not use up a limit of 1
        cur_req = "R7";
        retry_lim = 7'd1;
        ec(8'h75); ec(8'h05); ec(8'h05); ec(8'h05); exp_done.push_back(0);
        sb(8'h01); sb(8'h81); sb(8'h80);
        pulse(1, 0);
        wait_idle();

        // R10 limit 3 forces pass on third failure
        cur_req = "R10";
        retry_lim = 7'd3;
        ec(8'h75); ec(8'h05); ec(8'h05); ec(8'h05); exp_done.push_back(0);
        sb(8'h00); sb(8'h00); sb(8'h00);
        pulse(1, 0);
        wait_idle();

        // R6 two-byte read, mask on high byte
        cur_req = "R6";
        retry_lim = 7'd10; end_mask = 16'h8000; two_byte = 1;
        ec(8'h75); ec(8'h05); ec(8'h35); ec(8'h05); ec(8'h35); exp_done.push_back(0);
        sb(8'h00); sb(8'h00); sb(8'h00); sb(8'h80);
        pulse(1, 0);
        wait_idle();

        // R6 one-byte read leaves high byte zero: mask test fails until limit 2
        two_byte = 0; retry_lim = 7'd2;
        ec(8'h75); ec(8'h05); ec(8'h05); exp_done.push_back(0);
        sb(8'hFE); sb(8'hFE);
        pulse(1, 0);
        wait_idle();
        sus_full_chk = 0; end_mask = 16'h0080; retry_lim = 7'd4;

        // R9 full resume check needs masked bit clear
        cur_req = "R9";
        res_full_chk = 1;
        ec(8'h7A); ec(8'h05); ec(8'h05); exp_done.push_back(1);
        sb(8'h80); sb(8'h00);
        pulse(0, 1);
        wait_idle();
        res_full_chk = 0;

        // R5 waits: short unit, long unit, disabled for resume
        cur_req = "R5";
        sus_wait_en = 1; hold_len = 10'd3;
        ec(8'h75); ec(8'h05); exp_done.push_back(0); sb(8'h00);
        pulse(1, 0);
        wait_idle();
        check(last_gap == 13, "R5", last_gap, 13);
        hold_long = 1; hold_len = 10'd2;
        ec(8'h75); ec(8'h05); exp_done.push_back(0); sb(8'h00);
        pulse(1, 0);
        wait_idle();
        check(last_gap == 257, "R5", last_gap, 257);
        ec(8'h7A); ec(8'h05); exp_done.push_back(1); sb(8'h00);
        pulse(0, 1);
        wait_idle();
        check(last_gap == 1, "R5", last_gap, 1);
        sus_wait_en = 0; hold_long = 0; hold_len = '0;

        // R3 simultaneous strobes: suspend first
        cur_req = "R3";
        ec(8'h75); ec(8'h05); ec(8'h7A); ec(8'h05);
        exp_done.push_back(0); exp_done.push_back(1);
        sb(8'h00); sb(8'h00);
        pulse(1, 1);
        wait_idle();

        // R3 + R12 resume strobe while busy, with shifter stalls
        stall_en = 1;
        ec(8'h75); ec(8'h05); ec(8'h7A); ec(8'h05);
        exp_done.push_back(0); exp_done.push_back(1);
        sb(8'h00); sb(8'h00);
        pulse(1, 0);
        repeat (2) @(negedge clk);
        check(busy, "R3", busy, 1);
        pulse(0, 1);
        wait_idle();
        stall_en = 0;

        // R4 auto request ignored without enable
        cur_req = "R4";
        @(negedge clk); auto_req = 1;
        @(negedge clk); auto_req = 0;
        repeat (5) @(negedge clk);
        check(!busy && !sus_pend, "R4", {busy, sus_pend}, 0);
        auto_en = 1;
        ec(8'h75); ec(8'h05); exp_done.push_back(0); sb(8'h00);
        @(negedge clk); auto_req = 1;
        @(negedge clk); auto_req = 0;
        wait_idle();
        auto_en = 0;

        // R11 chain suspend into resume
        cur_req = "R11";
        chain_en = 1;
        ec(8'h75); ec(8'h05); ec(8'h7A); ec(8'h05);
        exp_done.push_back(0); exp_done.push_back(1);
        sb(8'h80); sb(8'h00);
        pulse(1, 0);
        wait_idle();
        check(!res_pend, "R11", res_pend, 0);
        chain_en = 0;

        if (!summary_done) begin
            summary_done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!summary_done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary_done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end
endmodule